// File: doc/BRIEF.md
# Operand Hazard and Interlock Unit

This block resolves operand hazards for an in-order integer pipeline of six stages: fetch, issue, decode, execute, memory and write. Each cycle it compares the source register numbers of the instruction sitting in decode with the destinations of the two older instructions it tracks in execute and in memory. From that comparison it produces an operand bypass select for each of the two sources, and it raises a stall request.

The bypass selects are registered. They take effect in the cycle in which the decoded instruction occupies execute. A stall freezes fetch, issue and decode. The unit then puts a bubble into execute in place of the held instruction. The bubble carries a cleared write enable and plain register file selects.

Besides the data case of using a loaded value too early, three structural conditions also raise the stall:
- a load-store unit still busy with a multi-register transfer;
- a missing load while the single hit-under-miss slot is occupied;
- a multiplier whose first stage is still in use.

Top module: `opnd_hazard_unit`

## Requirements
- R1: After a synchronous active-low reset, `fwd_a_sel`, `fwd_b_sel` and `ex_wr_en` read 0. With all request inputs low, `stall` reads 0.
- R2: When a valid decoded instruction uses a source whose number equals the destination of the instruction now in execute, and that producer's write enable is set, the select for that source reads 1 in the next cycle, provided no stall was raised. Select encoding: 0 = register file, 1 = producer one position ahead, 2 = producer two positions ahead.
- R3: When the only matching producer is the instruction in the memory stage, the select reads 2 in the next cycle, provided no stall was raised.
- R4: When a used source matches the destination of a load in execute that has its write enable set, `stall` is high in that same cycle.
- R5: A valid decoded load with `lsu_multi_busy` high raises `stall` in the same cycle.
- R6: `ld_miss` and `hum_full` both high raise `stall` in the same cycle, whatever is in decode.
- R7: A valid decoded multiply with `mul_s1_busy` high raises `stall` in the same cycle.
- R8: In the cycle after a stall, `ex_wr_en` is 0 and both selects are 0 (the injected bubble). In the cycle after an advance, `ex_wr_en` equals `dec_valid` AND `dec_rd_we` of the instruction that advanced.
- R9: When the execute and memory producers both match a source, the execute one wins (select 1).
- R10: A producer whose write enable is clear never matches. An unused source or an invalid decode slot selects 0. Register 0 matches like any other register.
- R11: `stall` is low in every cycle in which none of the conditions of R4 to R7 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_rs1 | input | AW | First source register number |
| dec_rs1_used | input | 1 | First source is read |
| dec_rs2 | input | AW | Second source register number |
| dec_rs2_used | input | 1 | Second source is read |
| dec_rd | input | AW | Destination register number |
| dec_rd_we | input | 1 | Instruction writes its destination |
| dec_is_load | input | 1 | Instruction is a load |
| dec_is_mul | input | 1 | Instruction is a multiply |
| lsu_multi_busy | input | 1 | Load-store unit still completing a multi-register transfer |
| ld_miss | input | 1 | Load in memory stage missed the cache |
| hum_full | input | 1 | Hit-under-miss slot already occupied |
| mul_s1_busy | input | 1 | Multiplier first stage still in use |
| stall | output | 1 | Freeze front stages, bubble into execute |
| fwd_a_sel | output | 2 | Bypass select for first source, valid in execute |
| fwd_b_sel | output | 2 | Bypass select for second source, valid in execute |
| ex_wr_en | output | 1 | Write enable of the instruction now in execute |

## Verification
`stall` is combinational and is due in the same cycle as the decode and structural inputs. The bench therefore samples it one time unit after it drives the inputs at the falling edge. The selects and `ex_wr_en` are due one rising edge later. The bench records their expected values when it drives an instruction and compares them at the next falling edge. A model in the bench shadows the execute and memory producers: it loads them on an advance and puts in a bubble on a stall. It sweeps every producer and consumer pairing over four register numbers, with each write-enable and load combination, and then runs a long pseudo-random mix that includes the structural requests.

// File: rtl/hzd_pkg.sv
// Shared types for the operand hazard unit.
// Assumes: select encoding is decoded by the execute-stage operand muxes.
package hzd_pkg;
    typedef enum logic [1:0] {
        SEL_RF   = 2'd0,   // register file value
        SEL_NEAR = 2'd1,   // producer one position ahead
        SEL_FAR  = 2'd2    // producer two positions ahead
    } fwd_sel_e;
endpackage

// File: rtl/hzd_track.sv
// Shadows destination info of the instructions in execute and memory.
// Assumes: advance is low whenever the front end is stalled; a bubble
// (write enable and load flag clear) then enters execute.
module hzd_track #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          dec_valid,
    input  logic [AW-1:0] dec_rd,
    input  logic          dec_we,
    input  logic          dec_ld,
    output logic [AW-1:0] ex_rd,
    output logic          ex_we,
    output logic          ex_ld,
    output logic [AW-1:0] mem_rd,
    output logic          mem_we
);
    // Move execute into memory every cycle; load decode or a bubble into execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_rd  <= '0;
            ex_we  <= 1'b0;
            ex_ld  <= 1'b0;
            mem_rd <= '0;
            mem_we <= 1'b0;
        end else begin
            mem_rd <= ex_rd;
            mem_we <= ex_we;
            if (advance) begin
                ex_rd <= dec_rd;
                ex_we <= dec_valid && dec_we;
                ex_ld <= dec_valid && dec_ld;
            end else begin
                ex_rd <= '0;
                ex_we <= 1'b0;
                ex_ld <= 1'b0;
            end
        end
    end

    // R8: the memory stage always holds what execute held one cycle earlier
    a_r8_mem_follows_ex: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_we == $past(ex_we)));
endmodule

// File: rtl/hzd_cmp.sv
// Compares each decode source against the execute and memory destinations.
// Assumes: a load in execute cannot forward; its match is reported as ld_use.
module hzd_cmp #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                      dec_valid,
    input  logic [NSRC-1:0][AW-1:0]   src,
    input  logic [NSRC-1:0]           src_used,
    input  logic [AW-1:0]             ex_rd,
    input  logic                      ex_we,
    input  logic                      ex_ld,
    input  logic [AW-1:0]             mem_rd,
    input  logic                      mem_we,
    output hzd_pkg::fwd_sel_e [NSRC-1:0] sel,
    output logic                      ld_use
);
    import hzd_pkg::*;

    logic [NSRC-1:0] hit_ex;
    logic [NSRC-1:0] hit_mem;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Match one source; the younger execute producer wins over memory.
        always_comb begin
            hit_ex[g]  = dec_valid && src_used[g] && ex_we  && (src[g] == ex_rd);
            hit_mem[g] = dec_valid && src_used[g] && mem_we && (src[g] == mem_rd);
            if (hit_ex[g])       sel[g] = SEL_NEAR;
            else if (hit_mem[g]) sel[g] = SEL_FAR;
            else                 sel[g] = SEL_RF;
        end
    end

    // Load-use hazard: a source needs the value a load in execute is fetching.
    assign ld_use = ex_ld && (|hit_ex);
endmodule

// File: rtl/hzd_stall.sv
// Merges the data interlock with the structural interlocks into one stall.
// Assumes: all request inputs are already synchronous to clk.
module hzd_stall (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_use,
    input  logic dec_valid,
    input  logic dec_ld,
    input  logic dec_mul,
    input  logic lsu_multi_busy,
    input  logic ld_miss,
    input  logic hum_full,
    input  logic mul_s1_busy,
    output logic stall
);
    logic ldm_block, hum_block, mul_block;

    // Evaluate each structural cause and combine with the data cause.
    always_comb begin
        ldm_block = dec_valid && dec_ld && lsu_multi_busy;
        hum_block = ld_miss && hum_full;
        mul_block = dec_valid && dec_mul && mul_s1_busy;
        stall     = ld_use || ldm_block || hum_block || mul_block;
    end

    // R7: a multiply never enters while the multiplier first stage is busy
    a_r7_mul_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_mul && mul_s1_busy) |-> stall);
    // R6: a miss with the hit-under-miss slot full always stalls
    a_r6_hum_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_miss && hum_full) |-> stall);
endmodule

// File: rtl/opnd_hazard_unit.sv
// Operand hazard and interlock unit for an in-order six-stage pipeline.
// Produces registered bypass selects for the instruction in execute and a
// combinational stall that freezes fetch, issue and decode.
// Assumes: decode holds its instruction while stall is high.
module opnd_hazard_unit #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [AW-1:0] dec_rs1,
    input  logic          dec_rs1_used,
    input  logic [AW-1:0] dec_rs2,
    input  logic          dec_rs2_used,
    input  logic [AW-1:0] dec_rd,
    input  logic          dec_rd_we,
    input  logic          dec_is_load,
    input  logic          dec_is_mul,
    input  logic          lsu_multi_busy,
    input  logic          ld_miss,
    input  logic          hum_full,
    input  logic          mul_s1_busy,
    output logic          stall,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          ex_wr_en
);
    import hzd_pkg::*;

    localparam int NSRC = 2;

    logic [AW-1:0] ex_rd, mem_rd;
    logic          ex_we, ex_ld, mem_we, ld_use;
    logic [NSRC-1:0][AW-1:0] src;
    logic [NSRC-1:0]         used;
    fwd_sel_e [NSRC-1:0]     sel;

    assign src  = {dec_rs2, dec_rs1};
    assign used = {dec_rs2_used, dec_rs1_used};

    hzd_track #(.AW(AW)) u_track (
        .clk(clk), .rst_n(rst_n), .advance(!stall),
        .dec_valid(dec_valid), .dec_rd(dec_rd), .dec_we(dec_rd_we),
        .dec_ld(dec_is_load),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld),
        .mem_rd(mem_rd), .mem_we(mem_we)
    );

    hzd_cmp #(.AW(AW), .NSRC(NSRC)) u_cmp (
        .dec_valid(dec_valid), .src(src), .src_used(used),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld),
        .mem_rd(mem_rd), .mem_we(mem_we),
        .sel(sel), .ld_use(ld_use)
    );

    hzd_stall u_stall (
        .clk(clk), .rst_n(rst_n), .ld_use(ld_use),
        .dec_valid(dec_valid), .dec_ld(dec_is_load), .dec_mul(dec_is_mul),
        .lsu_multi_busy(lsu_multi_busy), .ld_miss(ld_miss),
        .hum_full(hum_full), .mul_s1_busy(mul_s1_busy),
        .stall(stall)
    );

    // Latch selects for execute; a stall hands the bubble plain selects.
    always_ff @(posedge clk) begin
        if (!rst_n || stall) begin
            fwd_a_sel <= SEL_RF;
            fwd_b_sel <= SEL_RF;
        end else begin
            fwd_a_sel <= sel[0];
            fwd_b_sel <= sel[1];
        end
    end

    assign ex_wr_en = ex_we;

    // R8: a stall leaves a bubble with no write in execute
    a_r8_bubble_wen: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !ex_wr_en);
    // R8: the bubble carries register file selects
    a_r8_bubble_sel: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));
    // R2: only the three defined select codes ever appear
    a_r2_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel != 2'd3) && (fwd_b_sel != 2'd3));
endmodule

// File: tb/sim_opnd_hazard_unit.sv
module sim_opnd_hazard_unit;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, dec_rs1_used = 0, dec_rs2_used = 0, dec_rd_we = 0;
    logic dec_is_load = 0, dec_is_mul = 0;
    logic [AW-1:0] dec_rs1 = '0, dec_rs2 = '0, dec_rd = '0;
    logic lsu_multi_busy = 0, ld_miss = 0, hum_full = 0, mul_s1_busy = 0;
    logic stall, ex_wr_en;
    logic [1:0] fwd_a_sel, fwd_b_sel;

    always #5 clk = ~clk;   // 100 MHz

    opnd_hazard_unit #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .dec_rs1(dec_rs1), .dec_rs1_used(dec_rs1_used),
        .dec_rs2(dec_rs2), .dec_rs2_used(dec_rs2_used),
        .dec_rd(dec_rd), .dec_rd_we(dec_rd_we),
        .dec_is_load(dec_is_load), .dec_is_mul(dec_is_mul),
        .lsu_multi_busy(lsu_multi_busy), .ld_miss(ld_miss),
        .hum_full(hum_full), .mul_s1_busy(mul_s1_busy),
        .stall(stall), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .ex_wr_en(ex_wr_en)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // bench-side shadow of execute and memory producers
    logic [AW-1:0] m_ex_rd = '0, m_mem_rd = '0;
    logic m_ex_we = 0, m_ex_ld = 0, m_mem_we = 0;
    int p_a, p_b, p_w;
    string t_a, t_b;
    bit last_stall = 0;

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_sel(input logic [AW-1:0] rs, input logic u, output string tag);
        bit he, hm;
        he = dec_valid && u && m_ex_we && (rs == m_ex_rd);
        hm = dec_valid && u && m_mem_we && (rs == m_mem_rd);
        if (he && hm) begin tag = "R9"; return 1; end
        if (he) begin tag = "R2"; return 1; end
        if (hm) begin tag = "R3"; return 2; end
        tag = "R10";
        return 0;
    endfunction

    // one cycle: inputs already driven after a falling edge
    task automatic cycle();
        bit lu, es;
        string ts;
        #1;
        lu = dec_valid && m_ex_ld && m_ex_we &&
             ((dec_rs1_used && dec_rs1 == m_ex_rd) || (dec_rs2_used && dec_rs2 == m_ex_rd));
        es = 1'b1;
        if (lu) ts = "R4";
        else if (dec_valid && dec_is_load && lsu_multi_busy) ts = "R5";
        else if (ld_miss && hum_full) ts = "R6";
        else if (dec_valid && dec_is_mul && mul_s1_busy) ts = "R7";
        else begin ts = "R11"; es = 1'b0; end
        chk(ts, int'(stall), int'(es), "stall");
        if (es) begin
            p_a = 0; p_b = 0; p_w = 0; t_a = "R8"; t_b = "R8";
            m_mem_rd = m_ex_rd; m_mem_we = m_ex_we;
            m_ex_rd = '0; m_ex_we = 0; m_ex_ld = 0;
        end else begin
            p_a = exp_sel(dec_rs1, dec_rs1_used, t_a);
            p_b = exp_sel(dec_rs2, dec_rs2_used, t_b);
            p_w = int'(dec_valid && dec_rd_we);
            m_mem_rd = m_ex_rd; m_mem_we = m_ex_we;
            m_ex_rd = dec_rd; m_ex_we = dec_valid && dec_rd_we;
            m_ex_ld = dec_valid && dec_is_load;
        end
        last_stall = es;
        @(negedge clk);
        chk(t_a, int'(fwd_a_sel), p_a, "fwd_a_sel");
        chk(t_b, int'(fwd_b_sel), p_b, "fwd_b_sel");
        chk("R8", int'(ex_wr_en), p_w, "ex_wr_en");
    endtask

    task automatic set_dec(input bit v, input int rs1, input bit u1, input int rs2,
                           input bit u2, input int rd, input bit we, input bit ld,
                           input bit mul);
        dec_valid = v; dec_rs1 = AW'(rs1); dec_rs1_used = u1;
        dec_rs2 = AW'(rs2); dec_rs2_used = u2; dec_rd = AW'(rd);
        dec_rd_we = we; dec_is_load = ld; dec_is_mul = mul;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", int'(stall), 0, "stall after reset");
        chk("R1", int'(fwd_a_sel), 0, "fwd_a_sel after reset");
        chk("R1", int'(fwd_b_sel), 0, "fwd_b_sel after reset");
        chk("R1", int'(ex_wr_en), 0, "ex_wr_en after reset");
        @(negedge clk);

        // sweep producer (rd, we, load) against consumer sources, both slots
        for (int rd = 0; rd < 4; rd++)
            for (int w = 0; w < 2; w++)
                for (int l = 0; l < 2; l++)
                    for (int rs = 0; rs < 4; rs++) begin
                        set_dec(1, 0, 0, 0, 0, rd, w[0], l[0], 0);
                        cycle();
                        set_dec(1, rs, 1, 3 - rs, 1, 2, 1, 0, 0);
                        cycle();
                        while (last_stall) cycle();
                        set_dec(1, rd, 1, rs, rs[0], 1, 0, 0, 0);
                        cycle();
                        set_dec(0, rd, 1, rd, 1, 0, 0, 0, 0);
                        cycle();
                    end

        // directed: both producers write r1, consumer reads r1 (R9)
        set_dec(1, 0, 0, 0, 0, 1, 1, 0, 0); cycle();
        set_dec(1, 0, 0, 0, 0, 1, 1, 0, 0); cycle();
        set_dec(1, 1, 1, 1, 1, 2, 1, 0, 0); cycle();
        // directed structural stalls R5 R7 R6
        set_dec(1, 0, 0, 0, 0, 3, 1, 1, 0); lsu_multi_busy = 1; cycle();
        lsu_multi_busy = 0; cycle();
        set_dec(1, 0, 0, 0, 0, 3, 1, 0, 1); mul_s1_busy = 1; cycle();
        mul_s1_busy = 0; cycle();
        set_dec(0, 0, 0, 0, 0, 0, 0, 0, 0); ld_miss = 1; hum_full = 1; cycle();
        ld_miss = 0; hum_full = 0; cycle();

        // pseudo-random mix; decode holds while stalled
        for (int i = 0; i < 3000; i++) begin
            if (!last_stall)
                set_dec(($urandom % 4) != 0, $urandom % 4, $urandom % 2,
                        $urandom % 4, $urandom % 2, $urandom % 4, ($urandom % 4) != 0,
                        ($urandom % 3) == 0, ($urandom % 4) == 0);
            lsu_multi_busy = ($urandom % 6) == 0;
            ld_miss        = ($urandom % 3) == 0;
            hum_full       = ($urandom % 3) == 0;
            mul_s1_busy    = ($urandom % 5) == 0;
            cycle();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule